// File: doc/BRIEF.md
# Smart Card Pin Control and Card Presence Detector

This block sits between a smart card controller and the three card-side pins: bidirectional data (here driven as an output), card clock, and the card-detect switch input. Each of the two driven pins has a software path and a hardware path. The data pin is driven either by a register bit or by the serial data of a separate transfer engine. The clock pin is driven either by a register bit or by a programmable divider that makes a 50% duty clock.

The detect input passes through a synchronizer. It is then corrected for the switch type, so that presence always reads 1 when a card is in the slot. There is no debounce: every level change reaches the presence flag. Insertion and removal each latch a sticky flag, and the flags are combined into one gated interrupt. Software works the block through a small register port with four word addresses.

Register map (address: bits): CTRL=0: bit0 transfer mode, bit1 divider clock select, bit2 switch polarity, bit3 interrupt enable. PIN=1: bit0 software data, bit1 software clock. DIV=2: bits[5:0] divider setting N. STAT=3: bit0 presence (read only), bit1 insertion flag, bit2 removal flag (both write-1-to-clear). Unused bits read 0.

Top module: `sc_pin_ctrl`

## Requirements
- R1: After reset every register reads 0, and card_io_o, card_clk_o and irq_o are 0.
- R2: With CTRL bit0 = 0, card_io_o equals PIN bit0 from the cycle after that bit is written.
- R3: With CTRL bit0 = 1, card_io_o follows tx_data_i in the same cycle.
- R4: With CTRL bit1 = 0, card_clk_o equals PIN bit1 from the cycle after that bit is written.
- R5: With CTRL bit1 = 1, card_clk_o is a divided clock that starts low, goes high N+1 cycles after the select takes effect, and then stays high N+1 cycles and low N+1 cycles (period 2*(N+1), N=0 giving divide-by-2, N=63 giving divide-by-128).
- R6: Any write to DIV forces the divided clock low and restarts its count, so the next rising edge comes N+1 cycles after the write.
- R7: STAT bit0 equals the card_det_i level, inverted when CTRL bit2 = 1, and takes on each level change within three cycles, with no filtering.
- R8: A 0-to-1 change of presence sets STAT bit1 and a 1-to-0 change sets STAT bit2. Both flags hold until 1 is written to them, and writing 0 leaves them unchanged.
- R9: irq_o is 1 exactly when CTRL bit3 = 1 and STAT bit1 or bit2 is set.
- R10: A change of CTRL bit2 that flips presence does not set either sticky flag.
- R11: CTRL, PIN and DIV read back the values last written to their defined bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| tx_data_i | input | 1 | Serial data from the transfer engine |
| card_det_i | input | 1 | Raw card-detect switch level |
| card_io_o | output | 1 | Card data pin |
| card_clk_o | output | 1 | Card clock pin |
| irq_o | output | 1 | Card insertion/removal interrupt |

## Verification
The bench builds the block with its default parameters: a 6-bit divider setting and a two-stage synchronizer. The full divider range therefore fits within the run. The bench measures the divided clock at N=0, 1, 5 and 63, and the largest setting gives a 128-cycle period. The two-stage synchronizer fixes the detect latency at three cycles, so the presence, flag and polarity-masking checks can sample at exact cycles.

// File: rtl/sc_pin_pkg.sv
package sc_pin_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_PIN  = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_DIV  = 2'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 2'd3;

    // control word, packed so that mode is bit 0 and irq_en is bit 3
    typedef struct packed {
        logic irq_en;
        logic pol;
        logic clksel;
        logic mode;
    } sc_ctrl_t;

    localparam int unsigned CTRL_W = $bits(sc_ctrl_t);

    // status bit positions
    localparam int unsigned STAT_PRES = 0;
    localparam int unsigned STAT_INS  = 1;
    localparam int unsigned STAT_REM  = 2;

endpackage

// File: rtl/sc_pin_regs.sv
module sc_pin_regs
    import sc_pin_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PSC_W  = 6
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  we_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic                  present_i,
    input  logic                  ins_i,
    input  logic                  rem_i,
    output sc_ctrl_t              ctrl_o,
    output logic                  sw_data_o,
    output logic                  sw_clk_o,
    output logic [PSC_W-1:0]      psc_o,
    output logic                  div_wr_o,
    output logic                  clr_ins_o,
    output logic                  clr_rem_o,
    output logic [DATA_W-1:0]     rdata_o
);

    localparam int unsigned PAD_CTRL = DATA_W - CTRL_W;
    localparam int unsigned PAD_PSC  = DATA_W - PSC_W;

    typedef struct packed {
        sc_ctrl_t         ctrl;
        logic             sw_data;
        logic             sw_clk;
        logic [PSC_W-1:0] psc;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl, wr_pin, wr_div, wr_stat;

    always_comb begin
        wr_ctrl = we_i && (addr_i == ADDR_CTRL);
        wr_pin  = we_i && (addr_i == ADDR_PIN);
        wr_div  = we_i && (addr_i == ADDR_DIV);
        wr_stat = we_i && (addr_i == ADDR_STAT);

        r_d = r_q;
        if (wr_ctrl) begin
            r_d.ctrl = sc_ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
        if (wr_pin) begin
            r_d.sw_data = wdata_i[0];
            r_d.sw_clk  = wdata_i[1];
        end
        if (wr_div) begin
            r_d.psc = wdata_i[PSC_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_CTRL: rdata_o = {{PAD_CTRL{1'b0}}, r_q.ctrl};
            ADDR_PIN:  rdata_o = {{(DATA_W-2){1'b0}}, r_q.sw_clk, r_q.sw_data};
            ADDR_DIV:  rdata_o = {{PAD_PSC{1'b0}}, r_q.psc};
            default:   rdata_o = {{(DATA_W-3){1'b0}}, rem_i, ins_i, present_i};
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    assign ctrl_o    = r_q.ctrl;
    assign sw_data_o = r_q.sw_data;
    assign sw_clk_o  = r_q.sw_clk;
    assign psc_o     = r_q.psc;
    assign div_wr_o  = wr_div;
    assign clr_ins_o = wr_stat && wdata_i[STAT_INS];
    assign clr_rem_o = wr_stat && wdata_i[STAT_REM];

endmodule

// File: rtl/sc_prescaler.sv
module sc_prescaler #(
    parameter int unsigned PSC_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             clk_o
);

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
        logic             lvl;
    } presc_t;

    presc_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (restart_i || !en_i) begin
            p_d.cnt = '0;
            p_d.lvl = 1'b0;
        end else if (p_q.cnt == psc_i) begin
            p_d.cnt = '0;
            p_d.lvl = !p_q.lvl;
        end else begin
            p_d.cnt = p_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign clk_o = p_q.lvl;

endmodule

// File: rtl/sc_card_detect.sv
module sc_card_detect #(
    parameter int unsigned SYNC_N = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic det_i,
    input  logic pol_i,
    input  logic clr_ins_i,
    input  logic clr_rem_i,
    output logic present_o,
    output logic ins_o,
    output logic rem_o
);

    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              prev_pres;
        logic              prev_pol;
        logic              ins;
        logic              rem;
    } det_t;

    det_t d_d, d_q;
    logic present, pol_steady, rise, fall;

    always_comb begin
        present    = d_q.sync[SYNC_N-1] ^ pol_i;
        pol_steady = (pol_i == d_q.prev_pol);
        rise       = pol_steady &&  present && !d_q.prev_pres;
        fall       = pol_steady && !present &&  d_q.prev_pres;

        d_d           = d_q;
        d_d.sync      = {d_q.sync[SYNC_N-2:0], det_i};
        d_d.prev_pres = present;
        d_d.prev_pol  = pol_i;
        d_d.ins       = (d_q.ins && !clr_ins_i) || rise;
        d_d.rem       = (d_q.rem && !clr_rem_i) || fall;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign present_o = present;
    assign ins_o     = d_q.ins;
    assign rem_o     = d_q.rem;

endmodule

// File: rtl/sc_pin_ctrl.sv
module sc_pin_ctrl
    import sc_pin_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PSC_W  = 6,
    parameter int unsigned SYNC_N = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  reg_we_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    input  logic                  tx_data_i,
    input  logic                  card_det_i,
    output logic                  card_io_o,
    output logic                  card_clk_o,
    output logic                  irq_o
);

    sc_ctrl_t         ctrl_s;
    logic             sw_data_s, sw_clk_s, div_wr_s;
    logic             clr_ins_s, clr_rem_s;
    logic [PSC_W-1:0] psc_s;
    logic             present_s, ins_s, rem_s, div_clk_s;

    sc_pin_regs #(
        .DATA_W (DATA_W),
        .PSC_W  (PSC_W)
    ) i_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .present_i (present_s),
        .ins_i     (ins_s),
        .rem_i     (rem_s),
        .ctrl_o    (ctrl_s),
        .sw_data_o (sw_data_s),
        .sw_clk_o  (sw_clk_s),
        .psc_o     (psc_s),
        .div_wr_o  (div_wr_s),
        .clr_ins_o (clr_ins_s),
        .clr_rem_o (clr_rem_s),
        .rdata_o   (reg_rdata_o)
    );

    sc_prescaler #(
        .PSC_W (PSC_W)
    ) i_presc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (ctrl_s.clksel),
        .restart_i (div_wr_s),
        .psc_i     (psc_s),
        .clk_o     (div_clk_s)
    );

    sc_card_detect #(
        .SYNC_N (SYNC_N)
    ) i_detect (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .det_i     (card_det_i),
        .pol_i     (ctrl_s.pol),
        .clr_ins_i (clr_ins_s),
        .clr_rem_i (clr_rem_s),
        .present_o (present_s),
        .ins_o     (ins_s),
        .rem_o     (rem_s)
    );

    always_comb begin
        card_io_o  = ctrl_s.mode   ? tx_data_i : sw_data_s;
        card_clk_o = ctrl_s.clksel ? div_clk_s : sw_clk_s;
        irq_o      = ctrl_s.irq_en && (ins_s || rem_s);
    end

endmodule

// File: rtl/sc_pin_ctrl_chk.sv
module sc_pin_ctrl_chk
    import sc_pin_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PSC_W  = 6
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  reg_we_i,
    input logic [REG_ADDR_W-1:0] reg_addr_i,
    input logic [DATA_W-1:0]     reg_wdata_i,
    input logic                  tx_data_i,
    input logic                  card_io_o,
    input logic                  card_clk_o,
    input logic                  irq_o,
    input logic                  mode,
    input logic                  clksel,
    input logic                  pol,
    input logic [PSC_W-1:0]      psc,
    input logic                  ins,
    input logic                  rem
);

    // R2
    manual_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_addr_i == ADDR_PIN && !mode) |=> (card_io_o == $past(reg_wdata_i[0])));

    // R3
    transfer_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode |-> (card_io_o == tx_data_i));

    // R4
    manual_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_addr_i == ADDR_PIN && !clksel) |=> (card_clk_o == $past(reg_wdata_i[1])));

    // R5
    no_fast_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!reg_we_i && clksel && $past(clksel) && psc != '0 && card_clk_o != $past(card_clk_o))
        |=> $stable(card_clk_o));

    // R8
    ins_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ins && !(reg_we_i && reg_addr_i == ADDR_STAT && reg_wdata_i[STAT_INS])) |=> ins);

    // R8
    rem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rem && !(reg_we_i && reg_addr_i == ADDR_STAT && reg_wdata_i[STAT_REM])) |=> rem);

    // R9
    irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ins && !rem) |-> !irq_o);

    // R10
    pol_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pol != $past(pol)) |=> (!$rose(ins) && !$rose(rem)));

endmodule

bind sc_pin_ctrl sc_pin_ctrl_chk #(
    .DATA_W (DATA_W),
    .PSC_W  (PSC_W)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .tx_data_i   (tx_data_i),
    .card_io_o   (card_io_o),
    .card_clk_o  (card_clk_o),
    .irq_o       (irq_o),
    .mode        (ctrl_s.mode),
    .clksel      (ctrl_s.clksel),
    .pol         (ctrl_s.pol),
    .psc         (psc_s),
    .ins         (ins_s),
    .rem         (rem_s)
);

// File: tb/test_sc_pin_ctrl.sv
`timescale 1ns/1ps
module test_sc_pin_ctrl;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_PIN  = 2'd1;
    localparam logic [1:0] A_DIV  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tx_data = 1'b0;
    logic       det = 1'b0;
    logic       card_io, card_clk, irq;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    sc_pin_ctrl i_sc_pin_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .tx_data_i   (tx_data),
        .card_det_i  (det),
        .card_io_o   (card_io),
        .card_clk_o  (card_clk),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), v);
            chk("R1 reg reset", int'(v), 0);
        end
        chk("R1 io reset", int'(card_io), 0);
        chk("R1 clk reset", int'(card_clk), 0);
        chk("R1 irq reset", int'(irq), 0);
    endtask

    task automatic t_data_mux();
        wr(A_PIN, 8'h01);
        chk("R2 sw data 1", int'(card_io), 1);
        tx_data = 1'b0;
        wr(A_CTRL, 8'h01);
        chk("R3 tx low", int'(card_io), 0);
        tx_data = 1'b1; #1;
        chk("R3 tx high", int'(card_io), 1);
        tx_data = 1'b0;
        wr(A_CTRL, 8'h00);
        chk("R2 back to sw", int'(card_io), 1);
        wr(A_PIN, 8'h00);
        chk("R2 sw data 0", int'(card_io), 0);
    endtask

    task automatic t_clock_sw();
        logic [7:0] v;
        wr(A_PIN, 8'h02);
        chk("R4 sw clk 1", int'(card_clk), 1);
        chk("R4 io untouched", int'(card_io), 0);
        rd(A_PIN, v);
        chk("R11 pin readback", int'(v), 2);
        wr(A_PIN, 8'h00);
        chk("R4 sw clk 0", int'(card_clk), 0);
    endtask

    task automatic t_divide(input int n);
        int lo, hi, lo2;
        logic [7:0] v;
        wr(A_CTRL, 8'h00);
        wr(A_DIV, 8'(n));
        rd(A_DIV, v);
        chk("R11 div readback", int'(v), n);
        wr(A_CTRL, 8'h02);
        lo = 0;
        while (!card_clk && lo < 300) begin @(negedge clk); lo++; end
        hi = 0;
        while (card_clk && hi < 300) begin @(negedge clk); hi++; end
        lo2 = 0;
        while (!card_clk && lo2 < 300) begin @(negedge clk); lo2++; end
        chk("R5 first low", lo, n + 1);
        chk("R5 high time", hi, n + 1);
        chk("R5 low time", lo2, n + 1);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_restart();
        int k;
        wr(A_DIV, 8'd5);
        wr(A_CTRL, 8'h02);
        repeat (2) @(negedge clk);
        wr(A_DIV, 8'd5);
        k = 0;
        while (!card_clk && k < 300) begin @(negedge clk); k++; end
        chk("R6 restart low phase", k, 6);
        repeat (2) @(negedge clk);
        wr(A_DIV, 8'd5);
        chk("R6 restart forces low", int'(card_clk), 0);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_presence();
        logic [7:0] v;
        wr(A_STAT, 8'h06);
        det = 1'b1;
        repeat (4) @(negedge clk);
        rd(A_STAT, v);
        chk("R7 present + R8 insert", int'(v), 3);
        det = 1'b0;
        repeat (4) @(negedge clk);
        rd(A_STAT, v);
        chk("R7 absent + R8 remove", int'(v), 6);
        wr(A_STAT, 8'h00);
        rd(A_STAT, v);
        chk("R8 write 0 keeps flags", int'(v), 6);
        wr(A_STAT, 8'h02);
        rd(A_STAT, v);
        chk("R8 clear insert only", int'(v), 4);
        wr(A_STAT, 8'h04);
        rd(A_STAT, v);
        chk("R8 clear remove", int'(v), 0);
        // single-cycle glitch is still seen: no debounce
        @(negedge clk); det = 1'b1;
        @(negedge clk); det = 1'b0;
        repeat (5) @(negedge clk);
        rd(A_STAT, v);
        chk("R7 glitch not filtered", int'(v), 6);
        wr(A_STAT, 8'h06);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        det = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 irq gated off", int'(irq), 0);
        wr(A_CTRL, 8'h08);
        chk("R9 irq on", int'(irq), 1);
        rd(A_CTRL, v);
        chk("R11 ctrl readback", int'(v), 8);
        wr(A_STAT, 8'h02);
        chk("R9 irq cleared", int'(irq), 0);
        det = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 irq on removal", int'(irq), 1);
        wr(A_STAT, 8'h04);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_polarity();
        logic [7:0] v;
        wr(A_STAT, 8'h06);
        wr(A_CTRL, 8'h04);
        repeat (3) @(negedge clk);
        rd(A_STAT, v);
        chk("R10 pol set no event", int'(v), 1);
        wr(A_CTRL, 8'h00);
        repeat (3) @(negedge clk);
        rd(A_STAT, v);
        chk("R10 pol clear no event", int'(v), 0);
        wr(A_CTRL, 8'h04);
        det = 1'b1;
        repeat (4) @(negedge clk);
        rd(A_STAT, v);
        chk("R7 closed switch removal", int'(v), 4);
        det = 1'b0;
        repeat (4) @(negedge clk);
        rd(A_STAT, v);
        chk("R7 closed switch insert", int'(v), 7);
        wr(A_CTRL, 8'h00);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_mux();
        t_clock_sw();
        t_divide(0);
        t_divide(1);
        t_divide(5);
        t_divide(63);
        t_restart();
        t_presence();
        t_irq();
        t_polarity();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule